// File: doc/BRIEF.md
# DSI Peripheral Read Response Parser

This block runs one read transaction against a display peripheral from the host side of a DSI link. A start pulse brings in the request: the read packet type, its 16-bit parameter and the number of bytes wanted. The block first presents a set-maximum-return-size header carrying that byte count. It then presents the read request header itself. Next it waits for the receiver's RX-done event and parses the 32-bit words it pops from the RX FIFO.

The first word must carry the response type that fits the requested size. Short responses carry their data bytes in the first word. Long responses carry a length field, and the payload words follow. After the data one more word must hold the end-of-read marker. On any mismatch the block drains the FIFO, with an upper limit on the number of words it pops. It then reports a protocol error with length zero. Data bytes leave on a valid/ready byte stream. A single-cycle done pulse comes with a status code and the received length.

The header, RX word and byte interfaces are all valid/ready streams. A source holds valid and its data steady until ready is seen at a clock edge. When the byte stream is stalled, no further FIFO word is popped. A stall on the header stream only delays the transaction. Status codes: 0 success, 1 unsupported request type, 2 RX-done timeout, 3 response protocol error.

Top module: `dsi_read_parser`

## Requirements
- R1: A start whose request type is not one of 0x04, 0x14, 0x24 (generic read with 0, 1 or 2 parameters) or 0x06 (DCS read) presents no header. It gives a done pulse with status 1 and length 0.
- R2: A supported start presents two headers in order. The first has id 0x37 with the requested size as parameter. The second has the request type as id with the request parameter. Each is held stable until accepted.
- R3: The expected response type is 0x11 for size 1, 0x12 for size 2 and 0x1A for any other size. If bits 7:0 of the first RX word differ from it, the block drains and ends with status 3, length 0 and no bytes emitted.
- R4: For a size of 2 or less, bits 15:8 and then bits 23:16 of the first word give the data bytes, as many as the size.
- R5: For a size above 2, bits 23:8 of the first word must equal the size. Otherwise the block drains and ends with status 3 and length 0.
- R6: A long payload arrives in ceil(size/4) words, each unpacked little-endian (bits 7:0 first). Only size mod 4 bytes of a final partial word are emitted.
- R7: The word after the data must equal 0x30800002. If it does, the read ends with status 0 and length equal to the size. Otherwise the block drains and ends with status 3 and length 0.
- R8: The drain pops words until it pops the marker 0x30800002, or until DRAIN_LIMIT+2 words have been popped in the drain. It then ends with status 3 and length 0.
- R9: If RX-done does not arrive within TIMEOUT_CYC cycles of the second header being accepted, the read ends with status 2 and length 0, and no word is popped.
- R10: A byte offered on the byte stream stays valid and unchanged until accepted. No RX word is popped while a byte is pending, and done comes only after the last byte is accepted.
- R11: done is high for one cycle. Status and length hold their values until the next done. A start while busy is ignored. After reset the block is idle, status is 0 and length is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a read (ignored while busy) |
| req_type | input | 8 | Read request packet type |
| req_param | input | 16 | Parameter field of the read request header |
| req_size | input | SIZE_W | Requested byte count |
| busy | output | 1 | Transaction in progress |
| hdr_valid | output | 1 | Header offered |
| hdr_ready | input | 1 | Header accepted |
| hdr_id | output | 8 | Header packet type |
| hdr_param | output | 16 | Header parameter field |
| rx_done | input | 1 | Receiver reports a complete response |
| rx_valid | input | 1 | RX FIFO holds a word |
| rx_ready | output | 1 | Pop the RX FIFO word |
| rx_word | input | 32 | RX FIFO head word |
| byte_valid | output | 1 | Data byte offered |
| byte_ready | input | 1 | Data byte accepted |
| byte_data | output | 8 | Data byte |
| done | output | 1 | One-cycle end-of-read pulse |
| status | output | 2 | 0 ok, 1 bad request, 2 timeout, 3 protocol error |
| rx_len | output | SIZE_W | Bytes received on success, else 0 |

## Verification
The parser is tried with sizes 0, 1, 2, 3, 4, 5, 7, 8 and 9. These separate the short path from the long path, full payload words from a partial tail, and the size-0 case that expects a long type but takes the short path. Faulty responses carry a wrong type, a wrong length field or a wrong word where the marker belongs. Each fault is followed by a marker, so a drain that stops early or late shows as a wrong pop count. A marker-less flood checks the drain limit. Missing RX-done, an unsupported type, a start while busy and a toggling ready on both outgoing streams cover the remaining control paths.

// File: rtl/dsi_rd_pkg.sv
package dsi_rd_pkg;

  localparam logic [7:0] DT_SET_MAX_RET = 8'h37;
  localparam logic [7:0] DT_GEN_RD_P0   = 8'h04;
  localparam logic [7:0] DT_GEN_RD_P1   = 8'h14;
  localparam logic [7:0] DT_GEN_RD_P2   = 8'h24;
  localparam logic [7:0] DT_DCS_RD      = 8'h06;

  localparam logic [7:0] RSP_SHORT_1B   = 8'h11;
  localparam logic [7:0] RSP_SHORT_2B   = 8'h12;
  localparam logic [7:0] RSP_LONG       = 8'h1A;

  localparam logic [31:0] END_OF_READ   = 32'h3080_0002;

  typedef enum logic [1:0] {
    RD_OK      = 2'd0,
    RD_BADREQ  = 2'd1,
    RD_TIMEOUT = 2'd2,
    RD_PROTO   = 2'd3
  } rd_status_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_HDR_MAX,
    S_HDR_REQ,
    S_WAIT,
    S_FIRST,
    S_DATA,
    S_MARK,
    S_DRAIN
  } rd_state_e;

  function automatic logic req_type_ok(input logic [7:0] t);
    return (t == DT_GEN_RD_P0) || (t == DT_GEN_RD_P1) ||
           (t == DT_GEN_RD_P2) || (t == DT_DCS_RD);
  endfunction

endpackage

// File: rtl/dsi_rd_timer.sv
module dsi_rd_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!run)        cnt_q <= '0;
    else if (!expired)    cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == CW'(LIMIT - 1));

  // R9: the wait window never runs past its limit
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < CW'(LIMIT)));

endmodule

// File: rtl/dsi_rd_unpack.sv
module dsi_rd_unpack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld,
  input  logic [31:0] ld_word,
  input  logic [2:0]  ld_cnt,
  output logic        idle,
  output logic        o_valid,
  input  logic        o_ready,
  output logic [7:0]  o_data
);
  logic [31:0] shf_q;
  logic [2:0]  left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf_q  <= '0;
      left_q <= '0;
    end else if (ld) begin
      shf_q  <= ld_word;
      left_q <= ld_cnt;
    end else if (o_valid && o_ready) begin
      shf_q  <= {8'h00, shf_q[31:8]};
      left_q <= left_q - 1'b1;
    end
  end

  assign idle    = (left_q == '0);
  assign o_valid = !idle;
  assign o_data  = shf_q[7:0];

  // R10: a new word is only taken once every byte of the last one is gone
  a_r10_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> idle);

  // R10: an offered byte is held until accepted
  a_r10_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data)));

  // R6: at most one word's worth of bytes is pending
  a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= 3'd4);

endmodule

// File: rtl/dsi_read_parser.sv
module dsi_read_parser
  import dsi_rd_pkg::*;
#(
  parameter int SIZE_W      = 16,
  parameter int TIMEOUT_CYC = 4096,
  parameter int DRAIN_LIMIT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        req_type,
  input  logic [15:0]       req_param,
  input  logic [SIZE_W-1:0] req_size,
  output logic              busy,
  output logic              hdr_valid,
  input  logic              hdr_ready,
  output logic [7:0]        hdr_id,
  output logic [15:0]       hdr_param,
  input  logic              rx_done,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [31:0]       rx_word,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic [7:0]        byte_data,
  output logic              done,
  output logic [1:0]        status,
  output logic [SIZE_W-1:0] rx_len
);
  localparam int DCW = $clog2(DRAIN_LIMIT + 3);
  localparam logic [DCW-1:0] DRAIN_LAST = DCW'(DRAIN_LIMIT + 1);

  rd_state_e         st_q;
  logic [7:0]        type_q;
  logic [15:0]       param_q;
  logic [SIZE_W-1:0] size_q;
  logic [SIZE_W-1:0] rem_q;
  logic [DCW-1:0]    dcnt_q;
  logic              done_q;
  logic [1:0]        status_q;
  logic [SIZE_W-1:0] len_q;

  logic        pop;
  logic        tmo;
  logic [7:0]  exp_rsp;
  logic        short_rsp;
  logic [2:0]  chunk;
  logic        unp_idle;
  logic        unp_ld;
  logic [31:0] unp_word;
  logic [2:0]  unp_cnt;

  always_comb begin
    if (size_q == SIZE_W'(1))      exp_rsp = RSP_SHORT_1B;
    else if (size_q == SIZE_W'(2)) exp_rsp = RSP_SHORT_2B;
    else                           exp_rsp = RSP_LONG;
  end

  assign short_rsp = (size_q <= SIZE_W'(2));
  assign chunk     = (rem_q >= SIZE_W'(4)) ? 3'd4 : rem_q[2:0];

  always_comb begin
    unique case (st_q)
      S_FIRST, S_DRAIN: rx_ready = 1'b1;
      S_DATA, S_MARK:   rx_ready = unp_idle;
      default:          rx_ready = 1'b0;
    endcase
  end

  assign pop = rx_valid && rx_ready;

  assign unp_ld   = pop && (((st_q == S_FIRST) && (rx_word[7:0] == exp_rsp) && short_rsp) ||
                            (st_q == S_DATA));
  assign unp_word = (st_q == S_FIRST) ? {8'h00, rx_word[31:8]} : rx_word;
  assign unp_cnt  = (st_q == S_FIRST) ? size_q[2:0] : chunk;

  assign hdr_valid = (st_q == S_HDR_MAX) || (st_q == S_HDR_REQ);
  assign hdr_id    = (st_q == S_HDR_MAX) ? DT_SET_MAX_RET : type_q;
  assign hdr_param = (st_q == S_HDR_MAX) ? 16'(size_q) : param_q;
  assign busy      = (st_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      type_q   <= '0;
      param_q  <= '0;
      size_q   <= '0;
      rem_q    <= '0;
      dcnt_q   <= '0;
      done_q   <= 1'b0;
      status_q <= RD_OK;
      len_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start) begin
          type_q  <= req_type;
          param_q <= req_param;
          size_q  <= req_size;
          if (req_type_ok(req_type)) begin
            st_q <= S_HDR_MAX;
          end else begin
            done_q   <= 1'b1;
            status_q <= RD_BADREQ;
            len_q    <= '0;
          end
        end
        S_HDR_MAX: if (hdr_ready) st_q <= S_HDR_REQ;
        S_HDR_REQ: if (hdr_ready) st_q <= S_WAIT;
        S_WAIT: begin
          if (rx_done) begin
            st_q <= S_FIRST;
          end else if (tmo) begin
            st_q     <= S_IDLE;
            done_q   <= 1'b1;
            status_q <= RD_TIMEOUT;
            len_q    <= '0;
          end
        end
        S_FIRST: if (pop) begin
          dcnt_q <= '0;
          if (rx_word[7:0] != exp_rsp)             st_q <= S_DRAIN;
          else if (short_rsp)                      st_q <= S_MARK;
          else if (rx_word[23:8] != 16'(size_q))   st_q <= S_DRAIN;
          else begin
            rem_q <= size_q;
            st_q  <= S_DATA;
          end
        end
        S_DATA: if (pop) begin
          rem_q <= rem_q - SIZE_W'(chunk);
          if (rem_q <= SIZE_W'(4)) st_q <= S_MARK;
        end
        S_MARK: if (pop) begin
          dcnt_q <= '0;
          if (rx_word == END_OF_READ) begin
            st_q     <= S_IDLE;
            done_q   <= 1'b1;
            status_q <= RD_OK;
            len_q    <= size_q;
          end else begin
            st_q <= S_DRAIN;
          end
        end
        S_DRAIN: if (pop) begin
          dcnt_q <= dcnt_q + 1'b1;
          if ((rx_word == END_OF_READ) || (dcnt_q == DRAIN_LAST)) begin
            st_q     <= S_IDLE;
            done_q   <= 1'b1;
            status_q <= RD_PROTO;
            len_q    <= '0;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign done   = done_q;
  assign status = status_q;
  assign rx_len = len_q;

  dsi_rd_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (st_q == S_WAIT),
    .expired (tmo)
  );

  dsi_rd_unpack u_unpack (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (unp_ld),
    .ld_word (unp_word),
    .ld_cnt  (unp_cnt),
    .idle    (unp_idle),
    .o_valid (byte_valid),
    .o_ready (byte_ready),
    .o_data  (byte_data)
  );

  // R2: the size header is always followed by the request header
  a_r2_hdr_order: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready && hdr_id == DT_SET_MAX_RET) |=>
      (hdr_valid && hdr_id != DT_SET_MAX_RET));

  // R2: an offered header is held until accepted
  a_r2_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !hdr_ready) |=> (hdr_valid && $stable(hdr_id) && $stable(hdr_param)));

  // R11: single-cycle completion pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: status and length only move with done
  a_r11_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || ($stable(status) && $stable(rx_len))));

  // R3 R5 R8 R9: every failed read reports zero length
  a_r8_fail_len0: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != 2'(RD_OK)) |-> (rx_len == '0));

  // R8: drain pop count stays within its limit
  a_r8_drain_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DRAIN) |-> (dcnt_q <= DRAIN_LAST));

  // R10: completion never overtakes a pending byte
  a_r10_done_after_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !byte_valid);

endmodule

// File: tb/dsi_read_parser_tb.sv
module dsi_read_parser_tb_top;
  localparam int SW   = 16;
  localparam int TMO  = 64;
  localparam int DLIM = 20;
  localparam int NV   = 10;

  localparam logic [7:0]  V_TYPE [NV] = '{8'h14, 8'h06, 8'h04, 8'h24, 8'h06, 8'h06, 8'h06, 8'h06, 8'h06, 8'h06};
  localparam int          V_SIZE [NV] = '{1, 2, 4, 7, 9, 0, 2, 5, 3, 8};
  localparam logic [7:0]  V_CODE [NV] = '{8'h11, 8'h12, 8'h1A, 8'h1A, 8'h1A, 8'h1A, 8'h11, 8'h1A, 8'h1A, 8'h12};
  localparam int          V_LENF [NV] = '{0, 0, 4, 7, 9, 0, 0, 6, 3, 8};
  localparam bit          V_MOK  [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 1};
  localparam bit          V_BP   [NV] = '{0, 1, 0, 1, 1, 0, 0, 0, 0, 0};
  localparam logic [1:0]  V_ST   [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd3, 2'd3, 2'd3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] req_type = '0;
  logic [15:0] req_param = '0;
  logic [SW-1:0] req_size = '0;
  logic busy, hdr_valid, rx_ready, byte_valid, done;
  logic hdr_ready = 1'b1;
  logic byte_ready = 1'b1;
  logic rx_done = 1'b0;
  logic [7:0] hdr_id, byte_data;
  logic [15:0] hdr_param;
  logic [1:0] status;
  logic [SW-1:0] rx_len;
  logic rx_valid;
  logic [31:0] rx_word;

  logic [31:0] mem [64];
  logic [6:0] rd_ptr = '0;
  logic [6:0] wr_ptr = '0;
  bit clr = 1'b0;
  bit bp = 1'b0;
  int hcnt = 0, bcnt = 0;
  logic [7:0] hid [4];
  logic [15:0] hpar [4];
  logic [7:0] bbuf [64];
  bit d_seen = 1'b0;
  logic [1:0] d_st = '0;
  logic [SW-1:0] d_len = '0;
  int tests = 0, fails = 0;

  assign rx_valid = rd_ptr < wr_ptr;
  assign rx_word  = mem[rd_ptr[5:0]];

  always #5 clk = ~clk;

  dsi_read_parser #(.SIZE_W(SW), .TIMEOUT_CYC(TMO), .DRAIN_LIMIT(DLIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .req_type(req_type), .req_param(req_param),
    .req_size(req_size), .busy(busy), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_id(hdr_id), .hdr_param(hdr_param), .rx_done(rx_done), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_word(rx_word), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .done(done), .status(status), .rx_len(rx_len)
  );

  always @(posedge clk) begin
    if (clr) begin
      rd_ptr <= '0; hcnt <= 0; bcnt <= 0; d_seen <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rd_ptr <= rd_ptr + 1'b1;
      if (hdr_valid && hdr_ready) begin
        if (hcnt < 4) begin hid[hcnt] <= hdr_id; hpar[hcnt] <= hdr_param; end
        hcnt <= hcnt + 1;
      end
      if (byte_valid && byte_ready) begin
        if (bcnt < 64) bbuf[bcnt] <= byte_data;
        bcnt <= bcnt + 1;
      end
      if (done) begin d_seen <= 1'b1; d_st <= status; d_len <= rx_len; end
    end
  end

  always @(negedge clk) begin
    byte_ready <= bp ? ~byte_ready : 1'b1;
    hdr_ready  <= bp ? ~hdr_ready  : 1'b1;
  end

  function automatic logic [7:0] pb(input int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    mem[wr_ptr[5:0]] = w;
    wr_ptr = wr_ptr + 1'b1;
  endtask

  task automatic fill(input int size, input logic [7:0] code, input int lenf, input bit mok);
    wr_ptr = '0;
    if (size <= 2) begin
      push({8'h00, (size >= 2) ? pb(1) : 8'h00, (size >= 1) ? pb(0) : 8'h00, code});
    end else begin
      push({8'h00, 16'(lenf), code});
      for (int j = 0; j < (size + 3) / 4; j++) begin
        logic [31:0] w;
        w = '0;
        for (int k = 0; k < 4; k++)
          if (j * 4 + k < size) w[k*8 +: 8] = pb(j * 4 + k);
        push(w);
      end
    end
    if (!mok) push(32'hDEAD_BEEF);
    push(32'h3080_0002);
  endtask

  task automatic clear_mon();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic run(input logic [7:0] t, input logic [15:0] p, input int size,
                     input bit send_done, input bit poke);
    clear_mon();
    @(negedge clk);
    start = 1'b1; req_type = t; req_param = p; req_size = SW'(size);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 200 && hcnt < 2 && !d_seen; k++) @(negedge clk);
    if (poke) begin
      start = 1'b1; req_type = 8'h05; req_size = SW'(2);
      @(negedge clk);
      start = 1'b0;
    end
    repeat (3) @(negedge clk);
    if (send_done && !d_seen) begin
      rx_done = 1'b1;
      @(negedge clk);
      rx_done = 1'b0;
    end
    for (int k = 0; k < 3000 && !d_seen; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    string vreq [NV];
    vreq = '{"R4", "R4", "R6", "R6", "R6", "R4", "R3", "R5", "R7", "R3"};
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(busy == 1'b0, "R11 busy after reset", busy, 0);
    chk(done == 1'b0 && status == 2'd0 && rx_len == '0, "R11 status after reset", {done, status}, 0);
    chk(hdr_valid == 1'b0 && rx_ready == 1'b0 && byte_valid == 1'b0, "R10 idle streams after reset",
        {hdr_valid, rx_ready, byte_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int el;
      int bad;
      bp = V_BP[v];
      fill(V_SIZE[v], V_CODE[v], V_LENF[v], V_MOK[v]);
      run(V_TYPE[v], 16'h00A0 + 16'(v), V_SIZE[v], 1'b1, 1'b0);
      bp = 1'b0;
      el = (V_ST[v] == 2'd0) ? V_SIZE[v] : 0;
      chk(d_seen, {vreq[v], " done seen"}, d_seen, 1);
      chk(d_st == V_ST[v], {vreq[v], " status"}, d_st, V_ST[v]);
      chk(d_len == SW'(el), {vreq[v], " length"}, d_len, el);
      chk(rd_ptr == wr_ptr, "R8 words popped", rd_ptr, wr_ptr);
      chk(hcnt == 2 && hid[0] == 8'h37 && hpar[0] == 16'(V_SIZE[v]), "R2 size header",
          {hid[0], hpar[0]}, {8'h37, 16'(V_SIZE[v])});
      chk(hid[1] == V_TYPE[v] && hpar[1] == 16'h00A0 + 16'(v), "R2 request header",
          {hid[1], hpar[1]}, {V_TYPE[v], 16'h00A0 + 16'(v)});
      if (V_ST[v] == 2'd0) begin
        bad = 0;
        for (int i = 0; i < V_SIZE[v]; i++) if (bbuf[i] != pb(i)) bad++;
        chk(bcnt == V_SIZE[v], {vreq[v], " byte count"}, bcnt, V_SIZE[v]);
        chk(bad == 0, {vreq[v], " byte values R10"}, bad, 0);
      end
      if (v == 6 || v == 9) chk(bcnt == 0, "R3 no bytes on wrong type", bcnt, 0);
    end

    // R1: unsupported request type
    wr_ptr = '0;
    run(8'h05, 16'h0001, 2, 1'b0, 1'b0);
    chk(d_st == 2'd1 && d_len == '0, "R1 bad type status", {d_st, d_len}, {2'd1, 16'd0});
    chk(hcnt == 0, "R1 no header", hcnt, 0);

    // R9: no RX-done
    fill(1, 8'h11, 0, 1'b1);
    run(8'h06, 16'h0002, 1, 1'b0, 1'b0);
    chk(d_st == 2'd2 && d_len == '0, "R9 timeout status", {d_st, d_len}, {2'd2, 16'd0});
    chk(rd_ptr == '0, "R9 nothing popped", rd_ptr, 0);

    // R8: drain limit without marker
    wr_ptr = '0;
    push(32'h0000_0055);
    for (int i = 0; i < 30; i++) push(32'h1111_0000 + 32'(i));
    run(8'h06, 16'h0003, 4, 1'b1, 1'b0);
    chk(d_st == 2'd3 && d_len == '0, "R8 drain status", {d_st, d_len}, {2'd3, 16'd0});
    chk(rd_ptr == 7'(DLIM + 3), "R8 drain pop limit", rd_ptr, DLIM + 3);

    // R11: start while busy ignored, outputs held after done
    fill(1, 8'h11, 0, 1'b1);
    run(8'h14, 16'h0004, 1, 1'b1, 1'b1);
    chk(d_st == 2'd0 && d_len == SW'(1), "R11 busy start ignored", {d_st, d_len}, {2'd0, 16'd1});
    repeat (4) @(negedge clk);
    chk(done == 1'b0 && status == 2'd0 && rx_len == SW'(1), "R11 outputs held",
        {done, status, rx_len}, {1'b0, 2'd0, 16'd1});
    chk(busy == 1'b0, "R11 idle after read", busy, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule